// File: doc/BRIEF.md
# Word-FIFO to Byte-Card Data Engine

This block moves payload data between a word-wide FIFO, filled and drained by a host through a register port, and a byte-wide card data port. Software writes a byte length, then a control word whose low bit starts a transfer and whose next bit picks the direction. In the card-to-host direction, card bytes are packed into FIFO words, lowest byte lane first. In the host-to-card direction, FIFO words are split back into bytes, lowest lane first. The engine moves at most one byte per clock, so host FIFO accesses and card traffic can overlap freely.

Two countdowns pace the transfer. A byte counter tracks card traffic. A word counter allows exactly as many host accesses through the FIFO window as the length needs. When the byte counter runs out, sticky end flags are raised. When both counters are zero, the enable bit drops by itself. While a transfer is enabled, FIFO level flags are shown for the active direction only. Two interrupt lines each combine the status word with their own mask.

Top module: `fifo_byte_mover`

## Requirements
- R1: The FIFO holds 16 words of 32 bits and returns them in arrival order. A push into a full FIFO is dropped, and a pop from an empty FIFO returns 0 and changes nothing.
- R2: Writing the control register (offset 0x04) with bit 0 set loads the byte counter (readable at 0x08) from the length register (0x00), and loads the word counter (readable at 0x0C) with (length+3)>>2. The length register keeps only its low 16 bits. The control register keeps only its low 8 bits.
- R3: With control bit 1 set (card to host), card byte k of each group of four is placed in word bits [8k+7:8k]. A final partial word is still pushed, with its unused upper lanes at zero.
- R4: With control bit 1 clear (host to card), each popped word is sent as bytes from its least significant byte up. Each byte sent decrements the byte counter, and lanes left over when the count ends are dropped.
- R5: In the card-to-host direction a byte is taken only while card_ready is high and the FIFO is not full. In the host-to-card direction a byte is sent only when a word is held or the FIFO is not empty. At most one byte moves per clock.
- R6: Once the byte counter is zero with the engine enabled, status bits 8 and 10 are set. Once both counters are zero, control bit 0 clears and every FIFO flag reads zero. This includes a start with length 0.
- R7: While enabled, status (offset 0x10) shows one flag set only. For host-to-card the set is active 12, half-empty 14 (level at most 8), full 16 (level 16), empty 18 (level 0) and data-available 20 (level not 0). For card-to-host it is active 13, half-full 15 (level at least 8), full 17, empty 19 and data-available 21.
- R8: The FIFO window spans offsets 0x40 to 0x7C. An access there while the word counter is zero is ignored, and a read returns 0. Otherwise each access decrements the word counter and pushes or pops one word.
- R9: irq[i] is high when the status word ANDed with mask register i (offset 0x18 + 4*i) is non-zero. A write to the clear register (0x14) clears the status bits selected by the low 11 bits of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a FIFO window read pops at the clock edge |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| card_ready | input | 1 | Card has a byte available |
| card_rd_data | input | BYTE_W | Byte from the card |
| card_rd_en | output | 1 | Byte taken from the card this cycle |
| card_wr_en | output | 1 | Byte sent to the card this cycle |
| card_wr_data | output | BYTE_W | Byte to the card |
| irq | output | NUM_IRQ | Masked status interrupt lines |

## Verification
The bench builds the block with its defaults: a 16-word by 32-bit FIFO, 8-bit card bytes, a 16-bit length and two interrupt lines. These values make a full FIFO reachable with an 80-byte read, where the engine stalls with 16 bytes still owed. They also bring the half-level thresholds and the length masking within reach. A 10-byte read exercises a partial trailing word, and a 6-byte write drops two lanes of the last word.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
   // sticky status bits (cleared through the clear register)
   localparam int ST_DATA_END  = 8;
   localparam int ST_BLOCK_END = 10;
   localparam int CLR_BITS     = 11;
   // level flags, one set per direction
   localparam int ST_TX_ACT    = 12;
   localparam int ST_RX_ACT    = 13;
   localparam int ST_TX_HALF   = 14;
   localparam int ST_RX_HALF   = 15;
   localparam int ST_TX_FULL   = 16;
   localparam int ST_RX_FULL   = 17;
   localparam int ST_TX_EMPTY  = 18;
   localparam int ST_RX_EMPTY  = 19;
   localparam int ST_TX_AVAIL  = 20;
   localparam int ST_RX_AVAIL  = 21;
   localparam int STAT_W       = 32;
   // control bits
   localparam int CTL_EN       = 0;
   localparam int CTL_DIR      = 1;
   localparam int CTL_W        = 8;
   // register offsets (bytes)
   localparam logic [7:0] OFS_LEN   = 8'h00;
   localparam logic [7:0] OFS_CTRL  = 8'h04;
   localparam logic [7:0] OFS_BCNT  = 8'h08;
   localparam logic [7:0] OFS_WCNT  = 8'h0C;
   localparam logic [7:0] OFS_STAT  = 8'h10;
   localparam logic [7:0] OFS_CLR   = 8'h14;
   localparam logic [7:0] OFS_MASK0 = 8'h18;

   typedef enum logic {
      DIR_TO_CARD = 1'b0,
      DIR_TO_HOST = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/fbm_word_fifo.sv
module fbm_word_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [WIDTH-1:0]             push_data,
   input  logic                         pop,
   output logic [WIDTH-1:0]             head,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         full,
   output logic                         empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH-1)) != 0)) begin : g_bad_depth
      $error("fbm_word_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (level == $past(level)));
   // R1
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
endmodule

// File: rtl/fbm_byte_engine.sv
module fbm_byte_engine import fbm_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  xfer_dir_e         dir,
   input  logic              last_byte,
   input  logic              card_ready,
   input  logic [BYTE_W-1:0] card_rd_data,
   input  logic              fifo_full,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_head,
   input  logic              hold_push,
   input  logic              hold_pop,
   output logic              card_rd_en,
   output logic              card_wr_en,
   output logic [BYTE_W-1:0] card_wr_data,
   output logic              push,
   output logic [DATA_W-1:0] push_word,
   output logic              pop,
   output logic              step
);
   localparam int LANES  = DATA_W / BYTE_W;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

   if ((DATA_W % BYTE_W) != 0 || LANES < 2) begin : g_bad_lanes
      $error("fbm_byte_engine: DATA_W must hold at least two whole bytes");
   end

   logic [LANE_W-1:0] lane;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] shreg;
   logic              rd_go, wr_go, word_done;

   assign word_done = (lane == LANE_W'(LANES-1)) || last_byte;
   assign rd_go = run && (dir == DIR_TO_HOST) && card_ready && !fifo_full && !hold_push;
   assign wr_go = run && (dir == DIR_TO_CARD) &&
                  ((lane != '0) || (!fifo_empty && !hold_pop));

   assign card_rd_en   = rd_go;
   assign card_wr_en   = wr_go;
   assign card_wr_data = (lane == '0) ? fifo_head[BYTE_W-1:0] : shreg[BYTE_W-1:0];
   assign push         = rd_go && word_done;
   assign pop          = wr_go && (lane == '0);
   assign step         = rd_go || wr_go;

   // merge the incoming byte into its lane
   always_comb begin
      push_word = acc;
      for (int l = 0; l < LANES; l++) begin
         if (lane == LANE_W'(l)) push_word[l*BYTE_W +: BYTE_W] = card_rd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane  <= '0;
         acc   <= '0;
         shreg <= '0;
      end else if (restart) begin
         lane  <= '0;
         acc   <= '0;
      end else if (rd_go) begin
         lane <= word_done ? '0 : lane + 1'b1;
         acc  <= word_done ? '0 : push_word;
      end else if (wr_go) begin
         lane  <= word_done ? '0 : lane + 1'b1;
         shreg <= (lane == '0) ? (fifo_head >> BYTE_W) : (shreg >> BYTE_W);
      end
   end

   // R5
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rd_en |-> (card_ready && !fifo_full));
   // R4
   wr_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_wr_en && !word_done && !restart) |=> (card_wr_en || !run));
   // R5
   pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !fifo_empty);
endmodule

// File: rtl/fbm_status_irq.sv
module fbm_status_irq import fbm_pkg::*; #(
   parameter int DEPTH   = 16,
   parameter int NUM_IRQ = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [CLR_BITS-1:0]              set_vec,
   input  logic                             clr_we,
   input  logic [CLR_BITS-1:0]              clr_val,
   input  logic [NUM_IRQ-1:0]               mask_we,
   input  logic [STAT_W-1:0]                mask_wdata,
   input  logic                             active,
   input  xfer_dir_e                        dir,
   input  logic [$clog2(DEPTH+1)-1:0]       level,
   output logic [STAT_W-1:0]                status,
   output logic [NUM_IRQ-1:0][STAT_W-1:0]   masks,
   output logic [NUM_IRQ-1:0]               irq
);
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH/2);
   localparam logic [LVL_W-1:0] TOP  = LVL_W'(DEPTH);

   logic [CLR_BITS-1:0] sticky;
   logic [STAT_W-1:0]   flags;

   always_comb begin
      flags = '0;
      if (active) begin
         if (dir == DIR_TO_HOST) begin
            flags[ST_RX_ACT]   = 1'b1;
            flags[ST_RX_HALF]  = (level >= HALF);
            flags[ST_RX_FULL]  = (level == TOP);
            flags[ST_RX_EMPTY] = (level == '0);
            flags[ST_RX_AVAIL] = (level != '0);
         end else begin
            flags[ST_TX_ACT]   = 1'b1;
            flags[ST_TX_HALF]  = (level <= HALF);
            flags[ST_TX_FULL]  = (level == TOP);
            flags[ST_TX_EMPTY] = (level == '0);
            flags[ST_TX_AVAIL] = (level != '0);
         end
      end
   end

   assign status = flags | STAT_W'(sticky);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky <= '0;
      else        sticky <= (sticky & ~(clr_we ? clr_val : '0)) | set_vec;
   end

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          masks[g] <= '0;
         else if (mask_we[g]) masks[g] <= mask_wdata;
      end
      assign irq[g] = |(status & masks[g]);
   end

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_val[ST_DATA_END] && !set_vec[ST_DATA_END]) |=> !status[ST_DATA_END]);
   // R7
   one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[ST_TX_ACT] && status[ST_RX_ACT]));
endmodule

// File: rtl/fifo_byte_mover.sv
module fifo_byte_mover import fbm_pkg::*; #(
   parameter int FIFO_DEPTH = 16,
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int LEN_W      = 16,
   parameter int ADDR_W     = 7,
   parameter int NUM_IRQ    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               card_ready,
   input  logic [BYTE_W-1:0]  card_rd_data,
   output logic               card_rd_en,
   output logic               card_wr_en,
   output logic [BYTE_W-1:0]  card_wr_data,
   output logic [NUM_IRQ-1:0] irq
);
   localparam int LANES  = DATA_W / BYTE_W;
   localparam int SH     = $clog2(LANES);
   localparam int WCNT_W = LEN_W - SH + 1;
   localparam int LVL_W  = $clog2(FIFO_DEPTH+1);

   if (DATA_W < STAT_W) begin : g_bad_width
      $error("fifo_byte_mover: DATA_W must be at least the status width");
   end
   if ((FIFO_DEPTH * 4) > (2 ** (ADDR_W-1))) begin : g_bad_addr
      $error("fifo_byte_mover: ADDR_W too small for the FIFO window");
   end
   if (8'(OFS_MASK0 + 4*NUM_IRQ) > 8'(2 ** (ADDR_W-1))) begin : g_bad_irq
      $error("fifo_byte_mover: too many mask registers for ADDR_W");
   end

   // register decode
   logic in_win, ctrl_we, len_we, clr_we;
   logic [NUM_IRQ-1:0] mask_we;
   assign in_win  = reg_addr[ADDR_W-1];
   assign len_we  = reg_wr && !in_win && (reg_addr == ADDR_W'(OFS_LEN));
   assign ctrl_we = reg_wr && !in_win && (reg_addr == ADDR_W'(OFS_CTRL));
   assign clr_we  = reg_wr && !in_win && (reg_addr == ADDR_W'(OFS_CLR));
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mask_dec
      assign mask_we[g] = reg_wr && !in_win && (reg_addr == ADDR_W'(OFS_MASK0 + 4*g));
   end

   logic [LEN_W-1:0]  len_q;
   logic [CTL_W-1:0]  ctrl_q;
   logic [LEN_W-1:0]  bcnt;
   logic [WCNT_W-1:0] wcnt;
   logic              start, win_acc, host_push, host_pop;
   logic              f_full, f_empty, f_push, f_pop;
   logic [DATA_W-1:0] f_head, f_push_data;
   logic [LVL_W-1:0]  f_level;
   logic              e_push, e_pop, e_step;
   logic [DATA_W-1:0] e_word;
   xfer_dir_e         dir;
   logic              idle_now;
   logic [STAT_W-1:0] status;
   logic [NUM_IRQ-1:0][STAT_W-1:0] masks;
   logic [CLR_BITS-1:0] set_vec;

   assign dir      = xfer_dir_e'(ctrl_q[CTL_DIR]);
   assign start    = ctrl_we && reg_wdata[CTL_EN];
   assign win_acc  = in_win && (reg_wr || reg_rd) && (wcnt != '0);
   assign host_push = win_acc && reg_wr;
   assign host_pop  = win_acc && !reg_wr && reg_rd;
   assign idle_now = ctrl_q[CTL_EN] && (bcnt == '0) && (wcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         ctrl_q <= '0;
         bcnt   <= '0;
         wcnt   <= '0;
      end else begin
         if (len_we) len_q <= reg_wdata[LEN_W-1:0];
         if (ctrl_we)       ctrl_q <= reg_wdata[CTL_W-1:0];
         else if (idle_now) ctrl_q[CTL_EN] <= 1'b0;
         if (start) begin
            bcnt <= len_q;
            wcnt <= WCNT_W'(({1'b0, len_q} + (LEN_W+1)'(LANES-1)) >> SH);
         end else begin
            if (e_step)  bcnt <= bcnt - 1'b1;
            if (win_acc) wcnt <= wcnt - 1'b1;
         end
      end
   end

   // FIFO ports shared by host and engine; the host wins a collision
   assign f_push      = host_push || e_push;
   assign f_push_data = host_push ? reg_wdata : e_word;
   assign f_pop       = host_pop || e_pop;

   fbm_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(f_push), .push_data(f_push_data), .pop(f_pop),
      .head(f_head), .level(f_level), .full(f_full), .empty(f_empty)
   );

   fbm_byte_engine #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .restart(start),
      .run(ctrl_q[CTL_EN] && (bcnt != '0)),
      .dir(dir),
      .last_byte(bcnt == LEN_W'(1)),
      .card_ready(card_ready), .card_rd_data(card_rd_data),
      .fifo_full(f_full), .fifo_empty(f_empty), .fifo_head(f_head),
      .hold_push(host_push), .hold_pop(host_pop),
      .card_rd_en(card_rd_en), .card_wr_en(card_wr_en), .card_wr_data(card_wr_data),
      .push(e_push), .push_word(e_word), .pop(e_pop), .step(e_step)
   );

   always_comb begin
      set_vec = '0;
      if (ctrl_q[CTL_EN] && (bcnt == '0)) begin
         set_vec[ST_DATA_END]  = 1'b1;
         set_vec[ST_BLOCK_END] = 1'b1;
      end
   end

   fbm_status_irq #(.DEPTH(FIFO_DEPTH), .NUM_IRQ(NUM_IRQ)) u_status (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .clr_we(clr_we), .clr_val(reg_wdata[CLR_BITS-1:0]),
      .mask_we(mask_we), .mask_wdata(reg_wdata[STAT_W-1:0]),
      .active(ctrl_q[CTL_EN]), .dir(dir), .level(f_level),
      .status(status), .masks(masks), .irq(irq)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (in_win) begin
         reg_rdata = (wcnt != '0) ? f_head : '0;
      end else begin
         case (reg_addr)
            ADDR_W'(OFS_LEN):  reg_rdata = DATA_W'(len_q);
            ADDR_W'(OFS_CTRL): reg_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFS_BCNT): reg_rdata = DATA_W'(bcnt);
            ADDR_W'(OFS_WCNT): reg_rdata = DATA_W'(wcnt);
            ADDR_W'(OFS_STAT): reg_rdata = DATA_W'(status);
            default:           reg_rdata = '0;
         endcase
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (reg_addr == ADDR_W'(OFS_MASK0 + 4*i)) reg_rdata = DATA_W'(masks[i]);
         end
      end
   end

   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (bcnt == $past(len_q)));
   // R6
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_now && !ctrl_we) |=> !ctrl_q[CTL_EN]);
   // R8
   win_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && (reg_wr || reg_rd) && (wcnt == '0) && !start) |=> (wcnt == '0));
   // R5
   byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CTL_EN] && !start && (bcnt != '0)) |=> ((bcnt == $past(bcnt)) || (bcnt == $past(bcnt) - 1'b1)));
endmodule

// File: tb/test_fifo_byte_mover.sv
module test_fifo_byte_mover;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        card_ready = 1'b1;
   logic [7:0]  card_rd_data;
   logic        card_rd_en, card_wr_en;
   logic [7:0]  card_wr_data;
   logic [1:0]  irq;

   int n_tests = 0, n_fail = 0, wr_seen = 0;
   int rd_idx = 0;
   bit done = 0;
   logic [31:0] exp_words[$];
   logic [7:0]  exp_bytes[$];

   always #10 clk = ~clk;   // 50 MHz

   fifo_byte_mover i_fifo_byte_mover (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .card_ready(card_ready), .card_rd_data(card_rd_data),
      .card_rd_en(card_rd_en), .card_wr_en(card_wr_en),
      .card_wr_data(card_wr_data), .irq(irq)
   );

   // card source model: byte value follows a running index
   assign card_rd_data = 8'(rd_idx) + 8'hA0;
   always @(posedge clk) if (card_rd_en) rd_idx <= rd_idx + 1;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // card sink monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && card_wr_en) begin
         wr_seen++;
         if (exp_bytes.size() == 0) chk("R4", "unexpected card byte", {24'h0, card_wr_data}, 32'hxxxx_xxxx);
         else chk("R4", "card byte", {24'h0, card_wr_data}, {24'h0, exp_bytes.pop_front()});
      end
   end

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1 reg_rd = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [6:0] a, input logic [31:0] e);
      logic [31:0] d;
      rd(a, d);
      chk(req, $sformatf("reg %h", a), d, e);
   endtask

   // driver side of the scoreboard: expected words for a card-to-host run
   task automatic plan_read(input int base, input int len);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         logic [31:0] v = '0;
         for (int k = 0; k < 4; k++)
            if (w*4 + k < len) v[k*8 +: 8] = 8'(base + w*4 + k) + 8'hA0;
         exp_words.push_back(v);
      end
   endtask

   // monitor side: read words through the window and compare in order
   task automatic drain(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] d;
         rd(7'h40 + 7'((i % 16) * 4), d);
         if (exp_words.size() == 0) chk(req, "extra word", d, 32'hxxxx_xxxx);
         else chk(req, "fifo word", d, exp_words.pop_front());
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] d;
      idle(3); rst_n = 1'b1; idle(2);
      // reset state
      expect_reg("R6", 7'h10, 32'h0);
      expect_reg("R2", 7'h0C, 32'h0);
      chk("R9", "irq at reset", {30'h0, irq}, 32'h0);

      // register widths
      wr(7'h00, 32'h0001_2345);
      expect_reg("R2", 7'h00, 32'h0000_2345);
      wr(7'h04, 32'h0000_03F0);
      expect_reg("R2", 7'h04, 32'h0000_00F0);

      // 10-byte card-to-host run with a partial trailing word
      wr(7'h18, 32'h0000_0100);
      wr(7'h1C, 32'h0000_2000);
      wr(7'h00, 32'd10);
      plan_read(rd_idx, 10);
      wr(7'h04, 32'h3);
      expect_reg("R2", 7'h08, 32'd10);
      expect_reg("R2", 7'h0C, 32'd3);
      idle(20);
      expect_reg("R7", 7'h10, 32'h0020_2500);   // R6 end bits with RX active/avail
      chk("R9", "irq both", {30'h0, irq}, 32'h3);
      drain("R3", 3);
      idle(3);
      expect_reg("R6", 7'h04, 32'h2);
      expect_reg("R6", 7'h10, 32'h0000_0500);
      chk("R9", "irq after idle", {30'h0, irq}, 32'h1);

      // window access with zero word count
      rd(7'h40, d);
      chk("R8", "ignored window read", d, 32'h0);
      expect_reg("R8", 7'h0C, 32'h0);

      // clear register
      wr(7'h14, 32'h0000_0500);
      expect_reg("R9", 7'h10, 32'h0);
      chk("R9", "irq after clear", {30'h0, irq}, 32'h0);

      // 6-byte host-to-card run
      wr(7'h00, 32'd6);
      wr(7'h04, 32'h1);
      idle(2);
      expect_reg("R7", 7'h10, 32'h0004_5000);
      exp_bytes.push_back(8'h11); exp_bytes.push_back(8'h22);
      exp_bytes.push_back(8'h33); exp_bytes.push_back(8'h44);
      exp_bytes.push_back(8'h55); exp_bytes.push_back(8'h66);
      wr(7'h40, 32'h4433_2211);
      wr(7'h44, 32'h8877_6655);
      wr(7'h48, 32'hDEAD_BEEF);   // word count already zero
      idle(12);
      chk("R4", "bytes sent", wr_seen, 6);
      chk("R8", "no byte from ignored write", exp_bytes.size(), 0);
      expect_reg("R6", 7'h04, 32'h0);
      expect_reg("R6", 7'h10, 32'h0000_0500);
      wr(7'h14, 32'h7FF);

      // card not ready stalls a read
      card_ready = 1'b0;
      wr(7'h00, 32'd4);
      plan_read(rd_idx, 4);
      wr(7'h04, 32'h3);
      idle(10);
      expect_reg("R5", 7'h08, 32'd4);
      expect_reg("R7", 7'h10, 32'h0008_2000);
      chk("R9", "irq1 on RX active", {31'h0, irq[1]}, 32'h1);
      card_ready = 1'b1;
      idle(10);
      drain("R5", 1);
      idle(3);
      wr(7'h14, 32'h7FF);

      // 80-byte read fills the FIFO and stalls
      wr(7'h00, 32'd80);
      plan_read(rd_idx, 80);
      wr(7'h04, 32'h3);
      idle(100);
      expect_reg("R5", 7'h08, 32'd16);
      expect_reg("R7", 7'h10, 32'h0022_A000);
      drain("R1", 20);
      idle(3);
      expect_reg("R6", 7'h10, 32'h0000_0500);
      wr(7'h14, 32'h7FF);

      // zero length start
      wr(7'h00, 32'd0);
      wr(7'h04, 32'h3);
      idle(3);
      expect_reg("R6", 7'h04, 32'h2);
      expect_reg("R6", 7'h10, 32'h0000_0500);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule